// File: doc/BRIEF.md
# PC-Indexed Stride Prefetch Table

This block watches the stream of executed loads and learns, separately for each load instruction, whether that load walks memory with a constant step. Every load that retires presents its program counter and its effective address. The program counter selects one entry of a small direct-mapped table. The entry remembers the last address the load touched, the step it expects next, and a two-bit confidence state.

When the new address matches the previous address plus the remembered step, the prediction counts as correct. The confidence state then moves through a four-state machine (initial, transient, steady, no-prediction). On some wrong guesses the step is re-learned from the observed difference. Whenever an update leaves the entry in the steady state, the block raises a one-cycle prefetch request for the next address the load is expected to touch. A downstream cache or memory scheduler consumes this request. Filtering requests against cache contents is left to that consumer.

Top module: `stride_pf_table`

## Requirements
- R1: While `rst_n` is low at a clock edge, every entry becomes empty and `pf_valid` goes low. The first load of any PC after reset produces no prefetch.
- R2: A load whose entry is empty, or whose entry holds a different PC, replaces that entry. The new entry stores the full PC, previous address = load address, stride = 0 and state initial. `pf_valid` is low in the following cycle.
- R3: On a hit, the prediction is correct when the load address equals previous address plus stored stride, with arithmetic modulo 2^ADDR_W (negative strides wrap). The difference is load address minus previous address, also modulo 2^ADDR_W. On every hit the previous address becomes the load address.
- R4: From initial (code 0): correct moves to steady. Incorrect moves to transient and sets the stride to the difference.
- R5: From steady (code 2): correct stays steady. Incorrect moves to initial and keeps the stride.
- R6: From transient (code 1): correct moves to steady. Incorrect moves to no-prediction and sets the stride to the difference.
- R7: From no-prediction (code 3): correct moves to transient and keeps the stride. Incorrect stays in no-prediction and sets the stride to the difference.
- R8: `pf_valid` is high in the cycle right after a hit whose resulting state is steady, and low otherwise. `pf_addr` then equals the load address plus the resulting stride.
- R9: The table has 2^IDX_W = 16 entries, indexed by `ld_pc[IDX_LSB +: IDX_W]` (bits 5:2 by default). Loads with different index bits never affect each other. Two PCs that share an index evict each other.
- R10: A cycle with `ld_valid` low changes no entry and is followed by `pf_valid` low. Loads may arrive on consecutive cycles, and each one sees the table as updated by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| pf_valid | output | 1 | Prefetch request valid for this cycle |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The assertions assume that `ld_pc` and `ld_addr` are known whenever `ld_valid` is high. They also assume that reset is held for at least one clock edge before the first load, so that no entry is unknown when it is looked up. The stimulus drives every input at the falling edge from a fully specified value and keeps `ld_valid` low through reset. It walks each entry through every arc of the state machine, including wrapping negative strides, index aliasing and back-to-back loads. A pseudo-random phase then mixes several loads with occasional address jumps.

// File: rtl/spf_pkg.sv
// Shared definitions for the stride prefetch table.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package spf_pkg;

    // Per-entry confidence state; the codes are visible in the requirements.
    typedef enum logic [1:0] {
        SPF_INIT   = 2'd0,
        SPF_TRANS  = 2'd1,
        SPF_STEADY = 2'd2,
        SPF_NOPRED = 2'd3
    } spf_state_e;

endpackage

// File: rtl/spf_table.sv
// Direct-mapped storage of per-load history entries.
// One asynchronous read port (the looked-up entry) and one write port that
// commits at the rising edge. Assumes wr_idx is in range (ENTRIES = 2**IDX_W).
module spf_table
    import spf_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PC_W-1:0]   rd_pc,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output spf_state_e        rd_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  spf_state_e        wr_state
);

    localparam int ENTRIES = 1 << IDX_W;

    logic              ent_valid  [ENTRIES];
    logic [PC_W-1:0]   ent_pc     [ENTRIES];
    logic [ADDR_W-1:0] ent_prev   [ENTRIES];
    logic [ADDR_W-1:0] ent_stride [ENTRIES];
    spf_state_e        ent_state  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        // Clear one entry at reset, otherwise load it when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[e]  <= 1'b0;
                ent_pc[e]     <= '0;
                ent_prev[e]   <= '0;
                ent_stride[e] <= '0;
                ent_state[e]  <= SPF_INIT;
            end else if (sel) begin
                ent_valid[e]  <= 1'b1;
                ent_pc[e]     <= wr_pc;
                ent_prev[e]   <= wr_prev;
                ent_stride[e] <= wr_stride;
                ent_state[e]  <= wr_state;
            end
        end
    end

    // Present the indexed entry to the lookup logic.
    always_comb begin
        rd_valid  = ent_valid[rd_idx];
        rd_pc     = ent_pc[rd_idx];
        rd_prev   = ent_prev[rd_idx];
        rd_stride = ent_stride[rd_idx];
        rd_state  = ent_state[rd_idx];
    end

endmodule

// File: rtl/spf_fsm.sv
// Confidence state transition for one entry on a hit.
// Purely combinational. Assumes the caller applies it only to hits.
// relearn tells the datapath to replace the stride with the new difference.
module spf_fsm
    import spf_pkg::*;
(
    input  spf_state_e cur_state,
    input  logic       correct,
    output spf_state_e nxt_state,
    output logic       relearn
);

    // Transition table of the four-state confidence machine.
    always_comb begin
        nxt_state = cur_state;
        relearn   = 1'b0;
        unique case (cur_state)
            SPF_INIT: begin
                nxt_state = correct ? SPF_STEADY : SPF_TRANS;
                relearn   = !correct;
            end
            SPF_STEADY: begin
                nxt_state = correct ? SPF_STEADY : SPF_INIT;
                relearn   = 1'b0;
            end
            SPF_TRANS: begin
                nxt_state = correct ? SPF_STEADY : SPF_NOPRED;
                relearn   = !correct;
            end
            SPF_NOPRED: begin
                nxt_state = correct ? SPF_TRANS : SPF_NOPRED;
                relearn   = !correct;
            end
            default: begin
                nxt_state = SPF_INIT;
                relearn   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spf_calc.sv
// Update datapath for one observed load.
// Compares the load address with the stored prediction, picks the next
// entry contents (allocation on a miss, FSM step on a hit) and forms the
// prefetch target. Assumes inputs come straight from the table read port.
module spf_calc
    import spf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [ADDR_W-1:0] rd_prev,
    input  logic [ADDR_W-1:0] rd_stride,
    input  spf_state_e        rd_state,
    output logic              correct,
    output logic [ADDR_W-1:0] new_stride,
    output spf_state_e        new_state,
    output logic              issue,
    output logic [ADDR_W-1:0] pf_target
);

    logic [ADDR_W-1:0] predicted;
    logic [ADDR_W-1:0] delta;
    spf_state_e        fsm_state;
    logic              fsm_relearn;

    // Predicted address and observed step, both modulo 2**ADDR_W.
    always_comb begin
        predicted = rd_prev + rd_stride;
        delta     = ld_addr - rd_prev;
        correct   = (ld_addr == predicted);
    end

    spf_fsm u_fsm (
        .cur_state (rd_state),
        .correct   (correct),
        .nxt_state (fsm_state),
        .relearn   (fsm_relearn)
    );

    // Choose between allocation and the FSM step, and form the target.
    always_comb begin
        if (hit) begin
            new_state  = fsm_state;
            new_stride = fsm_relearn ? delta : rd_stride;
        end else begin
            new_state  = SPF_INIT;
            new_stride = '0;
        end
        issue     = hit && (new_state == SPF_STEADY);
        pf_target = ld_addr + new_stride;
    end

endmodule

// File: rtl/stride_pf_table.sv
// PC-indexed stride prefetch table (top).
// Each valid load looks up the entry chosen by its PC index bits, updates
// it in the same cycle, and raises a one-cycle prefetch request on the next
// cycle when the entry ends in the steady state.
// Assumes ld_pc and ld_addr are known whenever ld_valid is high.
module stride_pf_table
    import spf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid;
    logic [PC_W-1:0]   lk_pc;
    logic [ADDR_W-1:0] lk_prev;
    logic [ADDR_W-1:0] lk_stride;
    spf_state_e        lk_state;
    logic              lk_hit;
    logic              lk_correct;
    logic [ADDR_W-1:0] up_stride;
    spf_state_e        up_state;
    logic              up_issue;
    logic [ADDR_W-1:0] up_target;

    // Index selection and tag compare against the full stored PC.
    always_comb begin
        lk_idx = ld_pc[IDX_LSB +: IDX_W];
        lk_hit = lk_valid && (lk_pc == ld_pc);
    end

    spf_table #(
        .IDX_W  (IDX_W),
        .PC_W   (PC_W),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_valid  (lk_valid),
        .rd_pc     (lk_pc),
        .rd_prev   (lk_prev),
        .rd_stride (lk_stride),
        .rd_state  (lk_state),
        .wr_en     (ld_valid),
        .wr_idx    (lk_idx),
        .wr_pc     (ld_pc),
        .wr_prev   (ld_addr),
        .wr_stride (up_stride),
        .wr_state  (up_state)
    );

    spf_calc #(
        .ADDR_W (ADDR_W)
    ) u_calc (
        .hit        (lk_hit),
        .ld_addr    (ld_addr),
        .rd_prev    (lk_prev),
        .rd_stride  (lk_stride),
        .rd_state   (lk_state),
        .correct    (lk_correct),
        .new_stride (up_stride),
        .new_state  (up_state),
        .issue      (up_issue),
        .pf_target  (up_target)
    );

    // Register the prefetch request for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= ld_valid && up_issue;
            if (ld_valid && up_issue) begin
                pf_addr <= up_target;
            end
        end
    end

endmodule

// File: rtl/spf_checker.sv
// Temporal checks for the stride prefetch table, bound to the top module.
// Assumes reset is held for at least one edge before the first load.
module spf_checker
    import spf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              hit,
    input logic              correct,
    input logic [ADDR_W-1:0] prev,
    input spf_state_e        state
);

    // R8
    pf_from_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(ld_valid && hit && correct && state != SPF_NOPRED));

    // R8
    steady_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_valid && hit && correct && state != SPF_NOPRED))
        |-> pf_valid);

    // R3
    pf_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr == $past(ld_addr + ld_addr - prev)));

    // R2
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !hit) |=> !pf_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !pf_valid);

endmodule

bind stride_pf_table spf_checker #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .pf_valid (pf_valid),
    .pf_addr  (pf_addr),
    .hit      (lk_hit),
    .correct  (lk_correct),
    .prev     (lk_prev),
    .state    (lk_state)
);

// File: tb/sim_stride_pf_table.sv
// Scoreboard bench: the driver predicts each load's outcome from the
// requirements and queues it; the monitor compares after each clock edge.
module sim_stride_pf_table;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_pc = '0;
    logic [31:0] ld_addr = '0;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic        v;
        logic [31:0] a;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    // Bench model of the table, written from the requirements.
    logic        m_used  [16];
    logic [31:0] m_pc    [16];
    logic [31:0] m_prev  [16];
    logic [31:0] m_step  [16];
    int          m_st    [16];

    stride_pf_table u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_pc    (ld_pc),
        .ld_addr  (ld_addr),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] expv, input string what);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Drive one load at the falling edge and queue its expected outcome.
    task automatic load(input logic [31:0] pc, input logic [31:0] addr);
        exp_t e;
        int   i;
        i = int'(pc[5:2]);
        if (!m_used[i] || m_pc[i] != pc) begin
            m_used[i] = 1'b1;
            m_pc[i]   = pc;
            m_step[i] = 32'd0;
            m_st[i]   = 0;
            e.v = 1'b0; e.a = 32'd0; e.req = "R2";
        end else begin
            logic        ok;
            logic [31:0] diff;
            ok   = (addr == m_prev[i] + m_step[i]);
            diff = addr - m_prev[i];
            case (m_st[i])
                0: begin e.req = "R4"; if (ok) m_st[i] = 2; else begin m_st[i] = 1; m_step[i] = diff; end end
                2: begin e.req = "R5"; if (!ok) m_st[i] = 0; end
                1: begin e.req = "R6"; if (ok) m_st[i] = 2; else begin m_st[i] = 3; m_step[i] = diff; end end
                default: begin e.req = "R7"; if (ok) m_st[i] = 1; else m_step[i] = diff; end
            endcase
            e.v = (m_st[i] == 2);
            e.a = addr + m_step[i];
        end
        m_prev[i] = addr;
        exp_q.push_back(e);
        ld_valid = 1'b1;
        ld_pc    = pc;
        ld_addr  = addr;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        ld_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each cycle's result shortly after the edge.
    logic mon_v;
    always @(posedge clk) begin
        mon_v = ld_valid;
        if (rst_n) begin
            #(CLK_PERIOD/4);
            if (mon_v) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " (R8)"}, {31'd0, pf_valid}, {31'd0, e.v}, "pf_valid");
                if (e.v) check({e.req, " (R8)"}, pf_addr, e.a, "pf_addr");
            end else begin
                check("R10", {31'd0, pf_valid}, 32'd0, "pf_valid after idle");
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [31:0] cur [4];
        for (int k = 0; k < 16; k++) m_used[k] = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'd0, pf_valid}, 32'd0, "pf_valid after reset");
        idle(1);

        // Positive stride on PC 0x40 (index 0): R2, R4, R6, R5
        load(32'h0000_0040, 32'd100);   // miss (R1 first load, R2)
        load(32'h0000_0040, 32'd108);   // init wrong -> transient, stride 8
        load(32'h0000_0040, 32'd116);   // transient right -> steady, pf 124
        load(32'h0000_0040, 32'd124);   // steady, pf 132
        idle(3);                        // R10: idle keeps the entry
        load(32'h0000_0040, 32'd132);   // steady, pf 140
        load(32'h0000_0040, 32'd200);   // R5: steady wrong -> initial, stride kept
        load(32'h0000_0040, 32'd208);   // R4: initial right -> steady, pf 216
        idle(2);

        // No-prediction path on PC 0x44 (index 1): R6, R7
        load(32'h0000_0044, 32'h1000);
        load(32'h0000_0044, 32'h1004);  // stride 4, transient
        load(32'h0000_0044, 32'h1010);  // transient wrong -> no-pred, stride 12
        load(32'h0000_0044, 32'h1020);  // R7: stays, stride 16
        load(32'h0000_0044, 32'h1030);  // R7: right -> transient
        load(32'h0000_0044, 32'h1040);  // transient right -> steady, pf 0x1050
        idle(1);

        // R3: negative stride wrapping through zero on PC 0x48
        load(32'h0000_0048, 32'h10);
        load(32'h0000_0048, 32'h08);
        load(32'h0000_0048, 32'h00);    // steady, pf 0xFFFFFFF8
        load(32'h0000_0048, 32'hFFFF_FFF8);
        idle(1);

        // R9: aliasing at index 0 evicts, other index untouched
        load(32'h0000_0080, 32'd500);   // same index as 0x40, different PC
        load(32'h0000_0040, 32'd216);   // evicted: miss again
        load(32'h0000_0044, 32'h1050);  // index 1 still steady, pf 0x1060
        idle(1);

        // R10: back-to-back loads mixed across entries with jumps
        lfsr = 16'hACE1;
        for (int k = 0; k < 4; k++) cur[k] = 32'h2000 * (k + 1);
        for (int n = 0; n < 400; n++) begin
            int          p;
            logic [31:0] pc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            p  = int'(lfsr[1:0]);
            pc = (p == 3) ? 32'h0000_0140 : (32'h0000_0100 + 32'(p) * 32'h4);
            if (lfsr[7:4] == 4'h0) cur[p] = cur[p] + 32'h333;
            else cur[p] = cur[p] + 32'(p + 1) * 32'd16;
            load(pc, cur[p]);
            if (lfsr[11:9] == 3'd0) idle(1);
        end
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule